// File: doc/BRIEF.md
# Interruption Status Capture Unit

When the core takes an interruption, this unit records two 64-bit control registers. The first is a resume-address register, which tells the handler where execution continues. The second is a status register, which describes what caused the interruption. The pipeline raises a one-cycle capture strobe and supplies the context on the same cycle:

- the interruption class;
- the current and next instruction pointers;
- the slot indices;
- the access-kind flags;
- the translation deferral information;
- the collection-enable state;
- the legacy-mode flag;
- the code and vector values.

Both registers change on the clock edge at the end of the strobe cycle. They hold their value at all other times, and software reads them directly on two output ports.

The captured content depends on context:

- A fault resumes at the faulting instruction. A trap or external interrupt resumes at the next instruction.
- The slot field is taken from one of several sources.
- The deferral bit is suppressed whenever its translation source cannot be trusted.
- Legacy-mode interruptions clear every native-only field, and their address is truncated and zero-extended.

The resume-address register is written only while collection is enabled. The status register is written on every strobe, so that a nested interruption remains visible.

The capture strobe is a plain event pin, not a stream. The unit accepts a strobe on every cycle and applies no back-pressure. A strobe on the cycle after another one simply overwrites the first capture.

Top module: `isc_capture_unit`

## Requirements
- R1: While reset is asserted, both registers read zero, and a strobe during reset does not change them.
- R2: The status register takes its new value on the first rising edge after a cycle with `intr_strobe_i` high. On every other edge it keeps its value.
- R3: The resume-address register is written only on the edge after a cycle with both `intr_strobe_i` and `collect_en_i` high. Otherwise it keeps its value.
- R4: The class is encoded as 0 = fault, 1 = trap, 2 = external interrupt, and 3 is handled like 2. A fault saves `cur_ip_i`. Every other class saves `next_ip_i`.
- R5: In legacy mode the saved address is the low 32 bits of the selected pointer, zero-extended to 64 bits.
- R6: Status bits 31:24 and 63:44 always read zero.
- R7: The access flags sit at these positions: execute at bit 32, write at bit 33, read at bit 34 and non-access at bit 35. Each copies its input. In legacy mode `acc_rmw_i` sets both the read and the write bits; in native mode `acc_rmw_i` has no effect.
- R8: The slot field occupies bits 42:41. For traps it is 2 when `trap_long_imm_i` is set, and otherwise `trap_slot_i`. For all other classes it is `cur_slot_i`.
- R9: The deferral bit (bit 43) copies `xlat_defer_i` only when `xlat_valid_i` and `itrans_en_i` are both 1 and `regstack_i` is 0. Otherwise it is 0.
- R10: The nested bit (bit 39) is 1 when `collect_en_i` is 0 or `collect_chg_i` is 1.
- R11: In legacy mode the following fields are all 0: speculative (bit 36), register-stack (37), incomplete-frame (38), nested (39), slot and deferral.
- R12: The supervisor-override bit (bit 40) copies `sup_override_i` in legacy mode and is 0 in native mode. The vector field (bits 23:16) copies `vector_i` in legacy mode and is 0 in native mode.
- R13: The code field (bits 15:0) copies `code_i` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intr_strobe_i | input | 1 | Interruption taken this cycle |
| intr_class_i | input | 2 | Interruption class (0 fault, 1 trap, 2/3 external) |
| cur_ip_i | input | 64 | Pointer of the current instruction |
| next_ip_i | input | 64 | Pointer of the next instruction to execute |
| cur_slot_i | input | 2 | Current bundle slot index |
| trap_slot_i | input | 2 | Slot of the excepting instruction for traps |
| trap_long_imm_i | input | 1 | Trap raised by a two-slot long-immediate instruction |
| acc_fetch_i | input | 1 | Interruption tied to an instruction fetch |
| acc_read_i | input | 1 | Interruption tied to a read |
| acc_write_i | input | 1 | Interruption tied to a write |
| acc_rmw_i | input | 1 | Legacy read-modify-write access |
| acc_nonaccess_i | input | 1 | Non-access instruction |
| spec_load_i | input | 1 | Speculative load |
| regstack_i | input | 1 | Mandatory register-stack spill or fill |
| incomplete_i | input | 1 | Register frame incomplete |
| xlat_defer_i | input | 1 | Deferral bit of the instruction page translation |
| xlat_valid_i | input | 1 | A translation exists for the instruction page |
| itrans_en_i | input | 1 | Instruction translation enabled |
| collect_en_i | input | 1 | Interruption collection enabled |
| collect_chg_i | input | 1 | Collection-enable bit in flight |
| legacy_mode_i | input | 1 | Interruption taken in the legacy instruction set |
| sup_override_i | input | 1 | Legacy supervisor-override condition |
| code_i | input | 16 | Interruption code or legacy error code |
| vector_i | input | 8 | Legacy vector number |
| resume_addr_o | output | 64 | Resume-address register read port |
| status_o | output | 64 | Status register read port |

## Verification
The hardest case to reach is a nested capture, where the status register changes and the resume-address register must keep an older value. A flawed gate can look correct whenever the address happens to match. The stimulus therefore first loads a known address with collection enabled. It then strobes with collection disabled, using pointers different from the loaded address, and compares both registers against the reference model on every clock. Long-immediate traps, every deferral-suppression cause and legacy read-modify-write accesses are each driven directly. A long biased-random run then mixes modes and classes, including back-to-back strobes.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int unsigned ST_W    = 64;
  localparam int unsigned CODE_W  = 16;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned SLOT_W  = 2;
  localparam int unsigned FLAG_N  = 9;

  // bit positions that software decodes
  localparam int unsigned POS_CODE = 0;
  localparam int unsigned POS_VEC  = 16;
  localparam int unsigned POS_FLAG = 32;
  localparam int unsigned POS_SLOT = 41;
  localparam int unsigned POS_DEF  = 43;

  localparam logic [SLOT_W-1:0] SLOT_LONG_IMM = 2'd2;

  typedef enum logic [1:0] {
    ICLS_FAULT = 2'd0,
    ICLS_TRAP  = 2'd1,
    ICLS_EXT   = 2'd2,
    ICLS_RSVD  = 2'd3
  } icls_e;

  // packed so that bit 0 lands at status bit 32
  typedef struct packed {
    logic supov;
    logic nested;
    logic incompl;
    logic regstk;
    logic spec;
    logic nonacc;
    logic rd;
    logic wr;
    logic fetch;
  } isr_flags_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [VEC_W-1:0]  vec;
    isr_flags_t        fl;
    logic [SLOT_W-1:0] slot;
    logic              defer;
  } isr_fields_t;

  function automatic logic [ST_W-1:0] isr_pack(input isr_fields_t f);
    logic [ST_W-1:0] w;
    w = '0;
    w[POS_CODE +: CODE_W] = f.code;
    w[POS_VEC  +: VEC_W]  = f.vec;
    w[POS_FLAG +: FLAG_N] = f.fl;
    w[POS_SLOT +: SLOT_W] = f.slot;
    w[POS_DEF]            = f.defer;
    return w;
  endfunction

endpackage

// File: rtl/isc_resume_sel.sv
module isc_resume_sel
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEG_AW = 32
) (
  input  icls_e              cls,
  input  logic               legacy,
  input  logic [ADDR_W-1:0]  cur_ip,
  input  logic [ADDR_W-1:0]  next_ip,
  output logic [ADDR_W-1:0]  resume
);

  localparam int unsigned PAD_W = (LEG_AW < ADDR_W) ? (ADDR_W - LEG_AW) : 1;

  logic [ADDR_W-1:0] picked;

  // faults restart the faulting instruction, all other classes continue
  always_comb begin
    unique case (cls)
      ICLS_FAULT: picked = cur_ip;
      default:    picked = next_ip;
    endcase
  end

  generate
    if (LEG_AW < ADDR_W) begin : g_trunc
      logic [PAD_W-1:0] pad;
      assign pad    = '0;
      assign resume = legacy ? {pad, picked[LEG_AW-1:0]} : picked;
    end else begin : g_full
      assign resume = picked;
    end
  endgenerate

endmodule

// File: rtl/isc_slot_sel.sv
module isc_slot_sel
  import isc_pkg::*;
(
  input  icls_e              cls,
  input  logic               legacy,
  input  logic [SLOT_W-1:0]  cur_slot,
  input  logic [SLOT_W-1:0]  trap_slot,
  input  logic               long_imm,
  output logic [SLOT_W-1:0]  slot
);

  always_comb begin
    if (legacy) begin
      slot = '0;
    end else begin
      unique case (cls)
        ICLS_TRAP: slot = long_imm ? SLOT_LONG_IMM : trap_slot;
        default:   slot = cur_slot;
      endcase
    end
  end

endmodule

// File: rtl/isc_status_build.sv
module isc_status_build
  import isc_pkg::*;
(
  input  icls_e              cls,
  input  logic               legacy,
  input  logic [SLOT_W-1:0]  cur_slot,
  input  logic [SLOT_W-1:0]  trap_slot,
  input  logic               long_imm,
  input  logic               fetch,
  input  logic               rd,
  input  logic               wr,
  input  logic               rmw,
  input  logic               nonacc,
  input  logic               spec,
  input  logic               regstk,
  input  logic               incompl,
  input  logic               xdefer,
  input  logic               xvalid,
  input  logic               itrans,
  input  logic               ce,
  input  logic               ce_chg,
  input  logic               supov,
  input  logic [CODE_W-1:0]  code,
  input  logic [VEC_W-1:0]   vec,
  output logic [ST_W-1:0]    status
);

  isr_fields_t        f;
  logic [SLOT_W-1:0]  slot_w;
  logic               defer_ok;
  logic               rmw_leg;

  isc_slot_sel u_slot (
    .cls      (cls),
    .legacy   (legacy),
    .cur_slot (cur_slot),
    .trap_slot(trap_slot),
    .long_imm (long_imm),
    .slot     (slot_w)
  );

  assign rmw_leg  = legacy & rmw;
  // deferral source is trusted only with a live translation and no RSE traffic
  assign defer_ok = xvalid & itrans & ~regstk & ~legacy;

  always_comb begin
    f            = '0;
    f.code       = code;
    f.vec        = legacy ? vec : '0;
    f.fl.fetch   = fetch;
    f.fl.wr      = wr | rmw_leg;
    f.fl.rd      = rd | rmw_leg;
    f.fl.nonacc  = nonacc;
    f.fl.spec    = ~legacy & spec;
    f.fl.regstk  = ~legacy & regstk;
    f.fl.incompl = ~legacy & incompl;
    f.fl.nested  = ~legacy & (~ce | ce_chg);
    f.fl.supov   = legacy & supov;
    f.slot       = slot_w;
    f.defer      = defer_ok & xdefer;
  end

  assign status = isr_pack(f);

endmodule

// File: rtl/isc_capture_unit.sv
module isc_capture_unit
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEG_AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                intr_strobe_i,
  input  logic [1:0]          intr_class_i,
  input  logic [ADDR_W-1:0]   cur_ip_i,
  input  logic [ADDR_W-1:0]   next_ip_i,
  input  logic [1:0]          cur_slot_i,
  input  logic [1:0]          trap_slot_i,
  input  logic                trap_long_imm_i,
  input  logic                acc_fetch_i,
  input  logic                acc_read_i,
  input  logic                acc_write_i,
  input  logic                acc_rmw_i,
  input  logic                acc_nonaccess_i,
  input  logic                spec_load_i,
  input  logic                regstack_i,
  input  logic                incomplete_i,
  input  logic                xlat_defer_i,
  input  logic                xlat_valid_i,
  input  logic                itrans_en_i,
  input  logic                collect_en_i,
  input  logic                collect_chg_i,
  input  logic                legacy_mode_i,
  input  logic                sup_override_i,
  input  logic [15:0]         code_i,
  input  logic [7:0]          vector_i,
  output logic [ADDR_W-1:0]   resume_addr_o,
  output logic [63:0]         status_o
);

  icls_e              cls;
  logic [ADDR_W-1:0]  resume_d, resume_q;
  logic [ST_W-1:0]    status_d, status_q;

  assign cls = icls_e'(intr_class_i);

  isc_resume_sel #(.ADDR_W(ADDR_W), .LEG_AW(LEG_AW)) u_resume (
    .cls    (cls),
    .legacy (legacy_mode_i),
    .cur_ip (cur_ip_i),
    .next_ip(next_ip_i),
    .resume (resume_d)
  );

  isc_status_build u_status (
    .cls      (cls),
    .legacy   (legacy_mode_i),
    .cur_slot (cur_slot_i),
    .trap_slot(trap_slot_i),
    .long_imm (trap_long_imm_i),
    .fetch    (acc_fetch_i),
    .rd       (acc_read_i),
    .wr       (acc_write_i),
    .rmw      (acc_rmw_i),
    .nonacc   (acc_nonaccess_i),
    .spec     (spec_load_i),
    .regstk   (regstack_i),
    .incompl  (incomplete_i),
    .xdefer   (xlat_defer_i),
    .xvalid   (xlat_valid_i),
    .itrans   (itrans_en_i),
    .ce       (collect_en_i),
    .ce_chg   (collect_chg_i),
    .supov    (sup_override_i),
    .code     (code_i),
    .vec      (vector_i),
    .status   (status_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (intr_strobe_i) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_q <= '0;
    end else if (intr_strobe_i && collect_en_i) begin
      resume_q <= resume_d;
    end
  end

  assign resume_addr_o = resume_q;
  assign status_o      = status_q;

  p_hold_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_strobe_i |=> $stable(status_o));

  p_gate_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(intr_strobe_i && collect_en_i) |=> $stable(resume_addr_o));

  p_fault_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_strobe_i && collect_en_i && !legacy_mode_i && intr_class_i == 2'd0)
      |=> resume_addr_o == $past(cur_ip_i));

  p_legacy_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_strobe_i && collect_en_i && legacy_mode_i)
      |=> resume_addr_o[ADDR_W-1:LEG_AW] == '0);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:24] == '0 && status_o[63:44] == '0);

  p_defer_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_strobe_i && (!xlat_valid_i || !itrans_en_i || regstack_i)) |=> !status_o[43]);

  p_nested_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_strobe_i && !legacy_mode_i && !collect_en_i) |=> status_o[39]);

  p_legacy_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_strobe_i && legacy_mode_i) |=> (status_o[39:36] == '0 && status_o[43:41] == '0));

  p_native_supov_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_strobe_i && !legacy_mode_i) |=> (!status_o[40] && status_o[23:16] == '0));

endmodule

// File: tb/tb_isc_capture_unit.sv
module tb_isc_capture_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [1:0]  cls = '0;
  logic [63:0] cur_ip = '0, next_ip = '0;
  logic [1:0]  cur_slot = '0, trap_slot = '0;
  logic        long_imm = 0, fetch = 0, rd = 0, wr = 0, rmw = 0, nonacc = 0;
  logic        spec = 0, rs = 0, incompl = 0, xdef = 0, xval = 0, itr = 0;
  logic        ce = 0, chg = 0, legacy = 0, supov = 0;
  logic [15:0] code = '0;
  logic [7:0]  vec = '0;
  logic [63:0] addr_o, status_o;

  logic [63:0] m_addr, m_status;
  int checks = 0;
  int errors = 0;

  always #10ns clk = ~clk;

  isc_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .intr_strobe_i(strobe), .intr_class_i(cls),
    .cur_ip_i(cur_ip), .next_ip_i(next_ip), .cur_slot_i(cur_slot),
    .trap_slot_i(trap_slot), .trap_long_imm_i(long_imm),
    .acc_fetch_i(fetch), .acc_read_i(rd), .acc_write_i(wr), .acc_rmw_i(rmw),
    .acc_nonaccess_i(nonacc), .spec_load_i(spec), .regstack_i(rs),
    .incomplete_i(incompl), .xlat_defer_i(xdef), .xlat_valid_i(xval),
    .itrans_en_i(itr), .collect_en_i(ce), .collect_chg_i(chg),
    .legacy_mode_i(legacy), .sup_override_i(supov), .code_i(code),
    .vector_i(vec), .resume_addr_o(addr_o), .status_o(status_o)
  );

  // behavioural reference, written from the requirement list
  function automatic logic [63:0] ref_status();
    logic [63:0] s = '0;
    s[15:0] = code;
    s[32] = fetch;
    s[33] = wr | (legacy & rmw);
    s[34] = rd | (legacy & rmw);
    s[35] = nonacc;
    if (legacy) begin
      s[23:16] = vec;
      s[40] = supov;
    end else begin
      s[36] = spec;
      s[37] = rs;
      s[38] = incompl;
      s[39] = !ce || chg;
      if (cls == 2'd1) s[42:41] = long_imm ? 2'd2 : trap_slot;
      else             s[42:41] = cur_slot;
      s[43] = (xval && itr && !rs) ? xdef : 1'b0;
    end
    return s;
  endfunction

  function automatic logic [63:0] ref_addr();
    logic [63:0] a = (cls == 2'd0) ? cur_ip : next_ip;
    if (legacy) a = {32'h0, a[31:0]};
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr   <= '0;
      m_status <= '0;
    end else if (strobe) begin
      m_status <= ref_status();
      if (ce) m_addr <= ref_addr();
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 R4 R5 resume address", addr_o, m_addr);
    chk("R13 code field", {48'h0, status_o[15:0]}, {48'h0, m_status[15:0]});
    chk("R12 vector field", {56'h0, status_o[23:16]}, {56'h0, m_status[23:16]});
    chk("R7 access flags", {60'h0, status_o[35:32]}, {60'h0, m_status[35:32]});
    chk("R11 spec/regstack/incomplete", {61'h0, status_o[38:36]}, {61'h0, m_status[38:36]});
    chk("R10 nested", {63'h0, status_o[39]}, {63'h0, m_status[39]});
    chk("R12 supervisor override", {63'h0, status_o[40]}, {63'h0, m_status[40]});
    chk("R8 slot", {62'h0, status_o[42:41]}, {62'h0, m_status[42:41]});
    chk("R9 deferral", {63'h0, status_o[43]}, {63'h0, m_status[43]});
    chk("R6 reserved", {status_o[63:44], status_o[31:24]}, 64'h0);
    chk("R2 whole status", status_o, m_status);
  endtask

  task automatic quiet();
    strobe = 0; cls = 0; long_imm = 0; fetch = 0; rd = 0; wr = 0; rmw = 0;
    nonacc = 0; spec = 0; rs = 0; incompl = 0; xdef = 0; xval = 0; itr = 0;
    chg = 0; legacy = 0; supov = 0; cur_slot = 0; trap_slot = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic randomize_inputs();
    strobe   = ($urandom % 3) != 0;
    cls      = 2'($urandom);
    cur_ip   = {$urandom, $urandom};
    next_ip  = {$urandom, $urandom};
    cur_slot = 2'($urandom % 3);
    trap_slot = 2'($urandom % 3);
    long_imm = ($urandom % 4) == 0;
    {fetch, rd, wr, rmw, nonacc, spec, rs, incompl} = 8'($urandom);
    xdef = $urandom % 2; xval = ($urandom % 4) != 0; itr = ($urandom % 4) != 0;
    ce = ($urandom % 4) != 0; chg = ($urandom % 5) == 0;
    legacy = ($urandom % 3) == 0; supov = $urandom % 2;
    code = 16'($urandom); vec = 8'($urandom);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: strobe during reset must leave everything at zero
    quiet();
    strobe = 1; ce = 1; code = 16'hBEEF; cur_ip = 64'h1234; next_ip = 64'h5678;
    repeat (3) @(negedge clk);
    chk("R1 reset address", addr_o, 64'h0);
    chk("R1 reset status", status_o, 64'h0);
    strobe = 0;
    rst_n = 1;
    step();
    chk("R1 after release", addr_o | status_o, 64'h0);

    // R4 fault keeps current pointer, full-width native
    quiet(); ce = 1; strobe = 1; cls = 2'd0;
    cur_ip = 64'hFEDC_BA98_7654_3210; next_ip = 64'h1111_2222_3333_4444;
    cur_slot = 2'd1; xval = 1; itr = 1; xdef = 1; code = 16'h00A5;
    step();
    // R8 trap on long immediate form -> slot 2
    quiet(); ce = 1; strobe = 1; cls = 2'd1; long_imm = 1; trap_slot = 2'd0;
    step();
    // R9 each suppression cause
    quiet(); ce = 1; strobe = 1; xdef = 1; xval = 0; itr = 1; step();
    quiet(); ce = 1; strobe = 1; xdef = 1; xval = 1; itr = 0; step();
    quiet(); ce = 1; strobe = 1; xdef = 1; xval = 1; itr = 1; rs = 1; step();
    // R7 legacy read-modify-write, R5 truncation, R12 supervisor override
    quiet(); ce = 1; strobe = 1; legacy = 1; rmw = 1; supov = 1; vec = 8'd13;
    cls = 2'd2; next_ip = 64'hAAAA_BBBB_CCCC_DDDD; spec = 1; rs = 1; chg = 1;
    step();
    // R7 native rmw ignored
    quiet(); ce = 1; strobe = 1; rmw = 1; step();
    // R3 R10 nested capture leaves address alone
    quiet(); ce = 0; strobe = 1; cls = 2'd0; cur_ip = 64'h0F0F; step();
    quiet(); ce = 1; strobe = 0; cur_ip = 64'h7777; step();
    step();
    // R10 collection bit in flight
    quiet(); ce = 1; chg = 1; strobe = 1; step();

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      step();
    end
    quiet();
    step();
    step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule